// File: doc/BRIEF.md
# Two-Key Chord Sequence Lock

This block guards a 16-key pad and opens a lock only when the user enters a code made of two-key chords. A chord is a pair of keys held down together. There are three chords, called first, second and final. They must arrive in the order first, second, first, final, so the first chord counts twice. Each chord must be released completely before the next one is accepted. The block takes debounced key levels and a time-base `tick`. It drives `unlock` high for an external relay or solenoid driver. Pressing any key that is not part of the code resets the lock at once.

Two time windows apply. The first window opens when the first chord is released, and the second chord must arrive inside it. The second window opens when the second chord is recognised. The repeated first chord and the final chord must both arrive inside it, and `unlock` falls when it closes. Each window length is a parameter counted in ticks. At a 1 kHz tick the default of 5000 ticks gives about five seconds. The three chord masks can be loaded through a plain register-write port. All pins are plain control and status pins. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `chord_lock`

## Requirements
- R1: `rst` is synchronous and active high. On the first clock edge with `rst` high, the sequence returns to idle, `unlock` goes low, and the chord masks take their default values: first = 16'h0021, second = 16'h0300, final = 16'h4010 (bit n of a mask is key n).
- R2: A chord is recognised only when `keys` equals its mask exactly. A single key of a chord, or a chord plus another code key, does not advance the sequence.
- R3: After a chord is recognised, no further chord is accepted until `keys` has been all zero for one cycle. A chord that stays held through a key change therefore counts as one step only.
- R4: The gap window opens at the release that follows the first chord. The second chord is accepted only before the GAP_TICKS-th tick after that release. On that tick the sequence returns to idle, and a chord presented in the same cycle is not accepted.
- R5: The active window opens on the cycle the second chord is recognised; a tick in that same cycle is not counted. The repeated first chord and then the final chord must arrive before the ACT_TICKS-th tick that follows.
- R6: `unlock` goes high on the cycle after the final chord is recognised in its proper place. It stays high only while `keys` equals the final mask exactly, and it falls on the cycle after `keys` changes.
- R7: On the ACT_TICKS-th tick of the active window, the sequence returns to idle and `unlock` falls on the next cycle, even if the final chord is still held.
- R8: A pressed key that belongs to none of the three masks returns the sequence to idle on the next edge. This takes priority over every other event, and it also applies while `unlock` is high.
- R9: Chords presented out of order (for example the final chord while the repeated first chord is awaited) do not advance the sequence.
- R10: A cycle with `cfg_we` high loads `cfg_mask` into the mask chosen by `cfg_sel` (0 first, 1 second, 2 final) and returns the sequence to idle. A write with `cfg_sel` = 3 changes nothing.
- R11: A mask that does not have exactly two bits set never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse that advances the window counters |
| keys | input | 16 | Debounced key levels, 1 = pressed |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | 2 | Mask select: 0 first, 1 second, 2 final, 3 none |
| cfg_mask | input | 16 | Mask value to load |
| unlock | output | 1 | Lock drive, high while open |

## Verification
The bench goes after the timing edges. It expects the gap window to reject a second chord that arrives on its closing tick and to accept one arriving a tick earlier. A counter that is off by one would open or close one tick late. It holds the final chord while the active window expires; a design that latched the open state would keep `unlock` high. It also targets the step-counting paths: a long press that rolls from one chord into another, partial and oversized chords, out-of-order chords, and tamper keys pressed mid-sequence and while open. A design that missed any of these would step forward on stimulus that should be ignored. Mask writes are checked for their effect on the code, for the ignored select value, for the forced return to idle, and for a three-key mask that must never match.

// File: rtl/chord_lock_pkg.sv
package chord_lock_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_A1_HOLD,
    S_GAP,
    S_B_HOLD,
    S_B_WAIT,
    S_A2_HOLD,
    S_A2_WAIT,
    S_OPEN
  } lock_state_t;

  typedef enum logic [1:0] {
    PH_NONE,
    PH_GAP,
    PH_ACT
  } phase_t;

  localparam int CH_FIRST  = 0;
  localparam int CH_SECOND = 1;
  localparam int CH_FINAL  = 2;
  localparam int N_CHORDS  = 3;

  function automatic phase_t phase_of(lock_state_t s);
    case (s)
      S_GAP:                                              return PH_GAP;
      S_B_HOLD, S_B_WAIT, S_A2_HOLD, S_A2_WAIT, S_OPEN:   return PH_ACT;
      default:                                            return PH_NONE;
    endcase
  endfunction

endpackage

// File: rtl/chord_code_regs.sv
module chord_code_regs
  import chord_lock_pkg::*;
#(
  parameter int NKEYS = 16,
  parameter int SELW  = $clog2(N_CHORDS),
  parameter logic [N_CHORDS*NKEYS-1:0] DEF_MASKS = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [SELW-1:0]     cfg_sel,
  input  logic [NKEYS-1:0]    cfg_mask,
  input  logic [NKEYS-1:0]    keys,
  output logic [N_CHORDS-1:0] match,
  output logic                tamper,
  output logic                released,
  output logic                cfg_hit
);

  localparam logic [SELW-1:0] SEL_LAST = SELW'(N_CHORDS - 1);

  logic [NKEYS-1:0] mask_q [N_CHORDS];
  logic [NKEYS-1:0] code_union;

  assign cfg_hit = cfg_we && (cfg_sel <= SEL_LAST);

  for (genvar g = 0; g < N_CHORDS; g++) begin : g_chord
    always_ff @(posedge clk) begin
      if (rst)
        mask_q[g] <= DEF_MASKS[g*NKEYS +: NKEYS];
      else if (cfg_we && cfg_sel == SELW'(g))
        mask_q[g] <= cfg_mask;
    end

    // a chord matches only if its mask is a real pair and the pad shows exactly that pair
    assign match[g] = ($countones(mask_q[g]) == 2) && (keys == mask_q[g]);

    // R10: writes to other selects leave this mask alone
    p_mask_kept_r10: assert property (@(posedge clk) disable iff (rst)
      (!cfg_we || cfg_sel != SELW'(g)) |=> $stable(mask_q[g]));
    // R10: a write to this select lands the value
    p_mask_load_r10: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_sel == SELW'(g)) |=> mask_q[g] == $past(cfg_mask));
    // R11: a match always shows two pressed keys
    p_pair_only_r11: assert property (@(posedge clk) disable iff (rst)
      match[g] |-> $countones(keys) == 2);
  end

  always_comb begin
    code_union = '0;
    for (int i = 0; i < N_CHORDS; i++) code_union |= mask_q[i];
  end

  assign tamper   = |(keys & ~code_union);
  assign released = (keys == '0);

endmodule

// File: rtl/chord_window_timer.sv
module chord_window_timer #(
  parameter int GAP_TICKS = 5000,
  parameter int ACT_TICKS = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic use_act,
  input  logic tick,
  output logic expire
);

  localparam int MAXT = (GAP_TICKS > ACT_TICKS) ? GAP_TICKS : ACT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_TICKS - 1);
  localparam logic [CW-1:0] ACT_LAST = CW'(ACT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = use_act ? ACT_LAST : GAP_LAST;
  assign expire = run && tick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (run && tick)
      cnt_q <= cnt_q + 1'b1;
  end

  // R4/R5: the count never passes the last tick of the window in force
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt_q <= last);
  // R4: a clear leaves a fresh window
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && !rst) |=> cnt_q == '0);

endmodule

// File: rtl/chord_seq_fsm.sv
module chord_seq_fsm
  import chord_lock_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [N_CHORDS-1:0] match,
  input  logic                released,
  input  logic                tamper,
  input  logic                expire,
  input  logic                cfg_hit,
  output logic                tmr_clr,
  output logic                tmr_run,
  output logic                tmr_act,
  output logic                open
);

  lock_state_t state_q, state_d;
  phase_t      ph_q, ph_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:    if (match[CH_FIRST])  state_d = S_A1_HOLD;
      S_A1_HOLD: if (released)         state_d = S_GAP;
      S_GAP:     if (match[CH_SECOND]) state_d = S_B_HOLD;
      S_B_HOLD:  if (released)         state_d = S_B_WAIT;
      S_B_WAIT:  if (match[CH_FIRST])  state_d = S_A2_HOLD;
      S_A2_HOLD: if (released)         state_d = S_A2_WAIT;
      S_A2_WAIT: if (match[CH_FINAL])  state_d = S_OPEN;
      S_OPEN:    if (!match[CH_FINAL]) state_d = S_IDLE;
      default:                         state_d = S_IDLE;
    endcase
    if (tamper || expire || cfg_hit) state_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  assign ph_q    = phase_of(state_q);
  assign ph_d    = phase_of(state_d);
  assign tmr_run = (ph_q != PH_NONE);
  assign tmr_act = (ph_q == PH_ACT);
  assign tmr_clr = (ph_q == PH_NONE) || (ph_d != ph_q);
  assign open    = (state_q == S_OPEN);

  // R8: a foreign key always drops to idle
  p_tamper_idle_r8: assert property (@(posedge clk) disable iff (rst)
    tamper |=> state_q == S_IDLE);
  // R7: a closing window always drops to idle
  p_expire_idle_r7: assert property (@(posedge clk) disable iff (rst)
    expire |=> state_q == S_IDLE);
  // R10: a mask write abandons any progress
  p_cfg_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_hit |=> state_q == S_IDLE);
  // R9: the sequence only starts from the first chord
  p_start_first_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_A1_HOLD && $past(state_q) == S_IDLE) |-> $past(match[CH_FIRST]));
  // R3: a hold state is left only through a full release (or abort)
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_A1_HOLD && !released && !tamper && !cfg_hit) |=> state_q == S_A1_HOLD);

endmodule

// File: rtl/chord_lock.sv
module chord_lock
  import chord_lock_pkg::*;
#(
  parameter int NKEYS     = 16,
  parameter int GAP_TICKS = 5000,
  parameter int ACT_TICKS = 5000,
  parameter logic [NKEYS-1:0] CODE_FIRST  = 16'h0021,
  parameter logic [NKEYS-1:0] CODE_SECOND = 16'h0300,
  parameter logic [NKEYS-1:0] CODE_FINAL  = 16'h4010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [NKEYS-1:0] keys,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [NKEYS-1:0] cfg_mask,
  output logic             unlock
);

  localparam logic [N_CHORDS*NKEYS-1:0] DEFS = {CODE_FINAL, CODE_SECOND, CODE_FIRST};

  logic [N_CHORDS-1:0] match;
  logic tamper, released, cfg_hit;
  logic tmr_clr, tmr_run, tmr_act, expire;

  chord_code_regs #(
    .NKEYS(NKEYS), .SELW(2), .DEF_MASKS(DEFS)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mask(cfg_mask),
    .keys(keys), .match(match), .tamper(tamper), .released(released), .cfg_hit(cfg_hit)
  );

  chord_window_timer #(
    .GAP_TICKS(GAP_TICKS), .ACT_TICKS(ACT_TICKS)
  ) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run), .use_act(tmr_act),
    .tick(tick), .expire(expire)
  );

  chord_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .match(match), .released(released), .tamper(tamper),
    .expire(expire), .cfg_hit(cfg_hit), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .tmr_act(tmr_act), .open(unlock)
  );

  // R1: the cycle after a reset edge is always locked
  p_reset_locked_r1: assert property (@(posedge clk)
    $past(rst) |-> !unlock);
  // R6: the lock is open only if the previous cycle showed a two-key chord
  p_open_pair_r6: assert property (@(posedge clk) disable iff (rst)
    unlock |-> $countones($past(keys)) == 2);

endmodule

// File: tb/sim_chord_lock.sv
module sim_chord_lock;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] keys = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_mask = '0;
  logic        unlock;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  chord_lock #(.GAP_TICKS(3), .ACT_TICKS(6)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .keys(keys), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_mask(cfg_mask), .unlock(unlock)
  );

  // {req, keys, tick, expected unlock}; masks first 0021, second 0300, final 4010
  localparam int NV = 64;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1,16'h0000,1'b0,1'b0},
    {4'd2,16'h0021,1'b0,1'b0}, {4'd2,16'h0000,1'b0,1'b0}, {4'd2,16'h0300,1'b0,1'b0},
    {4'd2,16'h0000,1'b0,1'b0}, {4'd2,16'h0021,1'b0,1'b0}, {4'd2,16'h0000,1'b0,1'b0},
    {4'd6,16'h4010,1'b0,1'b1}, {4'd6,16'h4010,1'b0,1'b1}, {4'd6,16'h0000,1'b0,1'b0},
    // R2: single key, then half of the second chord
    {4'd2,16'h0001,1'b0,1'b0}, {4'd2,16'h0000,1'b0,1'b0}, {4'd2,16'h0021,1'b0,1'b0},
    {4'd2,16'h0000,1'b0,1'b0}, {4'd2,16'h0100,1'b0,1'b0}, {4'd2,16'h0000,1'b0,1'b0},
    {4'd2,16'h0300,1'b0,1'b0}, {4'd2,16'h0000,1'b0,1'b0},
    // R9: final chord out of order
    {4'd9,16'h4010,1'b0,1'b0}, {4'd9,16'h0000,1'b0,1'b0}, {4'd9,16'h0021,1'b0,1'b0},
    {4'd9,16'h0000,1'b0,1'b0}, {4'd9,16'h4010,1'b0,1'b1},
    // R6: extra code key while open
    {4'd6,16'h4011,1'b0,1'b0}, {4'd6,16'h0000,1'b0,1'b0},
    // R3: long press rolling into the second chord
    {4'd3,16'h0021,1'b0,1'b0}, {4'd3,16'h0321,1'b0,1'b0}, {4'd3,16'h0300,1'b0,1'b0},
    {4'd3,16'h0000,1'b0,1'b0}, {4'd3,16'h0021,1'b0,1'b0}, {4'd3,16'h0000,1'b0,1'b0},
    {4'd3,16'h4010,1'b0,1'b0}, {4'd8,16'h0002,1'b0,1'b0}, {4'd8,16'h0000,1'b0,1'b0},
    // R4: gap closes on the third tick
    {4'd4,16'h0021,1'b0,1'b0}, {4'd4,16'h0000,1'b0,1'b0}, {4'd4,16'h0000,1'b1,1'b0},
    {4'd4,16'h0000,1'b1,1'b0}, {4'd4,16'h0000,1'b1,1'b0}, {4'd4,16'h0300,1'b0,1'b0},
    {4'd4,16'h0000,1'b0,1'b0}, {4'd4,16'h0021,1'b0,1'b0}, {4'd4,16'h0000,1'b0,1'b0},
    {4'd4,16'h4010,1'b0,1'b0}, {4'd8,16'h0002,1'b0,1'b0},
    // R4: second chord one tick before closing
    {4'd4,16'h0021,1'b0,1'b0}, {4'd4,16'h0000,1'b0,1'b0}, {4'd4,16'h0000,1'b1,1'b0},
    {4'd4,16'h0000,1'b1,1'b0}, {4'd4,16'h0300,1'b0,1'b0}, {4'd4,16'h0000,1'b0,1'b0},
    {4'd4,16'h0021,1'b0,1'b0}, {4'd4,16'h0000,1'b0,1'b0}, {4'd5,16'h4010,1'b0,1'b1},
    {4'd5,16'h0000,1'b0,1'b0},
    // R5/R7: active window, tick every cycle, expires with final chord held
    {4'd5,16'h0021,1'b0,1'b0}, {4'd5,16'h0000,1'b0,1'b0}, {4'd5,16'h0300,1'b0,1'b0},
    {4'd5,16'h0000,1'b1,1'b0}, {4'd5,16'h0021,1'b1,1'b0}, {4'd5,16'h0000,1'b1,1'b0},
    {4'd5,16'h4010,1'b1,1'b1}, {4'd7,16'h4010,1'b1,1'b1}, {4'd7,16'h4010,1'b1,1'b0}
  };

  task automatic step(input logic [15:0] k, input logic t, input logic e, input string r);
    keys = k;
    tick = t;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    n_run++;
    if (unlock !== e) begin
      n_fail++;
      $display("FAIL %s: unlock=%0b expected %0b (keys=%h)", r, unlock, e, k);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] m);
    keys = '0;
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_mask = m;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // walks first/second/first with releases, leaving the final chord awaited
  task automatic enter_three(input logic [15:0] a, input logic [15:0] b, input string r);
    step(a, 1'b0, 1'b0, r);
    step('0, 1'b0, 1'b0, r);
    step(b, 1'b0, 1'b0, r);
    step('0, 1'b0, 1'b0, r);
    step(a, 1'b0, 1'b0, r);
    step('0, 1'b0, 1'b0, r);
  endtask

  initial begin
    @(negedge clk);
    step('0, 1'b0, 1'b0, "R1");          // R1: locked while in reset
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      step(v[17:2], v[1], v[0], $sformatf("R%0d", v[21:18]));
    end
    step('0, 1'b0, 1'b0, "R7");          // R7: stays locked after expiry

    // R8: tamper mid-sequence, then the final chord must not open
    enter_three(16'h0021, 16'h0300, "R8");
    step(16'h0002, 1'b0, 1'b0, "R8");
    step('0, 1'b0, 1'b0, "R8");
    step(16'h4010, 1'b0, 1'b0, "R8");
    step('0, 1'b0, 1'b0, "R8");
    // R8: tamper while open, final chord plus a foreign key
    enter_three(16'h0021, 16'h0300, "R8");
    step(16'h4010, 1'b0, 1'b1, "R8");
    step(16'h4012, 1'b0, 1'b0, "R8");
    step(16'h4010, 1'b0, 1'b0, "R8");
    step('0, 1'b0, 1'b0, "R8");

    // R10: new first chord 0006 takes effect
    load(2'd0, 16'h0006);
    enter_three(16'h0006, 16'h0300, "R10");
    step(16'h4010, 1'b0, 1'b1, "R10");
    step('0, 1'b0, 1'b0, "R10");
    // R10: select 3 is ignored, code still works
    load(2'd3, 16'h00ff);
    enter_three(16'h0006, 16'h0300, "R10");
    step(16'h4010, 1'b0, 1'b1, "R10");
    step('0, 1'b0, 1'b0, "R10");
    // R10: a write mid-sequence forces idle
    enter_three(16'h0006, 16'h0300, "R10");
    load(2'd1, 16'h0300);
    step(16'h4010, 1'b0, 1'b0, "R10");
    step('0, 1'b0, 1'b0, "R10");

    // R11: three-key final mask never matches
    load(2'd2, 16'h4013);
    enter_three(16'h0006, 16'h0300, "R11");
    step(16'h4013, 1'b0, 1'b0, "R11");
    step('0, 1'b0, 1'b0, "R11");

    // R1: reset restores the default masks and locks an open lock
    rst = 1'b1;
    step('0, 1'b0, 1'b0, "R1");
    rst = 1'b0;
    enter_three(16'h0021, 16'h0300, "R1");
    step(16'h4010, 1'b0, 1'b1, "R1");
    rst = 1'b1;
    step(16'h4010, 1'b0, 1'b0, "R1");
    rst = 1'b0;
    step('0, 1'b0, 1'b0, "R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule